// File: doc/BRIEF.md
# SPI Slave Byte Memory Bridge

This block lets an external SPI master read and write a small byte-wide memory inside the chip. Every transaction is a fixed three-byte frame. The first byte is an opcode, the second is an address, and the third is either data to store or a dummy byte that clocks out the stored value. The serial pins are sampled in the system clock domain through a synchronizer chain, and SCK edges are detected there. The system clock must therefore run at least eight times faster than SCK.

The bus uses a clock that idles low. The slave samples MOSI on the falling SCK edge and updates MISO on the rising edge, most significant bit first. Releasing chip select at any point drops a partly received frame and re-aligns both the bit and byte counters. After three complete bytes the frame logic starts over, even when chip select stays low.

Every completed byte is also copied into a single holding register that local logic can watch. An overflow flag records any byte that arrived before the previous one was taken.

Top module: `spi_byte_mem_slave`

## Requirements
- R1: A first byte of 0xF0 selects a write and 0x0F selects a read. For any other first byte, nothing is stored, the third byte is discarded, and MISO stays 0 for the whole frame.
- R2: A write frame (0xF0, address, data) stores the data byte at the address when the third byte completes.
- R3: In a read frame (0x0F, address, dummy), MISO is 0 during the first two bytes. During the third byte it carries the byte stored at the address.
- R4: SCK idles low. MOSI is sampled on the falling SCK edge and MISO changes on the rising edge. Bytes travel most significant bit first in both directions.
- R5: Raising chip select discards any partial frame, whether it is one byte, two bytes or part of a byte. Such a frame leaves memory unchanged, and the next frame starts cleanly.
- R6: After three bytes the frame restarts while chip select stays low. The following three bytes are decoded as a new frame.
- R7: The memory holds DEPTH bytes (255 by default) and every entry reads 0 after reset.
- R8: Addresses at or above DEPTH (0xFF at the default size) have no storage. Writes to them are ignored and reads return 0.
- R9: Every completed byte is copied to rx_byte and raises rx_ready, which stays high until rx_take is pulsed.
- R10: If a byte completes while rx_ready is high and rx_take is low, rx_ovf is set. It stays set until rx_ovf_clr is pulsed.
- R11: While chip select is high, MISO is 0 and the bit counter is held at zero. SCK pulses in that state do not shift the alignment of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the master |
| rx_byte | output | BYTE_W | Last completed received byte |
| rx_ready | output | 1 | Holding register contains an untaken byte |
| rx_take | input | 1 | One-cycle pulse that consumes the held byte |
| rx_ovf | output | 1 | Sticky overflow flag of the holding register |
| rx_ovf_clr | input | 1 | One-cycle pulse that clears rx_ovf |

## Verification
The bench builds the block with DEPTH set to 12 and keeps the default byte width and two synchronizer stages. With only twelve storage entries, a full sweep of addresses 0 to 15 writes and reads every entry. The same sweep, plus address 0xFF, also covers the addresses that have no storage, and it stays within a short run. Distinct data patterns per address show bit order on MISO. Aborted frames, stray clocks with chip select high, and back-to-back frames under one chip select are each followed by read-backs, so any disturbance shows up at the pins.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   typedef enum logic [1:0] {
      SLOT_OP   = 2'd0,
      SLOT_ADDR = 2'd1,
      SLOT_DATA = 2'd2
   } slot_e;
endpackage

// File: rtl/sbm_sync.sv
module sbm_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sbm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_in};
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/sbm_shifter.sv
module sbm_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_idle,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              miso,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   if (BYTE_W < 2) begin : g_bad_width
      $error("sbm_shifter: BYTE_W must be at least 2");
   end

   logic              sck_prev;
   logic              sck_rise, sck_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic              miso_q;

   assign sck_rise  =  sck_s & ~sck_prev;
   assign sck_fall  = ~sck_s &  sck_prev;
   assign byte_val  = {rx_sh[BYTE_W-2:0], mosi_s};
   assign byte_done = sck_fall & ~cs_idle & (bit_cnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         miso_q  <= 1'b0;
      end else if (cs_idle) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         miso_q  <= 1'b0;
      end else begin
         if (sck_fall) begin
            rx_sh   <= byte_val;
            bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
         end
         if (tx_load) begin
            tx_sh <= tx_data;
         end else if (sck_rise) begin
            miso_q <= tx_sh[BYTE_W-1];
            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assign miso = miso_q;
endmodule

// File: rtl/sbm_store.sv
module sbm_store #(
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BYTE_W-1:0] waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] raddr,
   output logic [BYTE_W-1:0] rdata
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1 || DEPTH > (1 << BYTE_W)) begin : g_bad_depth
      $error("sbm_store: DEPTH must lie in 1 .. 2**BYTE_W");
   end

   logic [BYTE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < DEPTH; r++) cells[r] <= '0;
      end else begin
         for (int r = 0; r < DEPTH; r++) begin
            if (we && waddr == BYTE_W'(r)) cells[r] <= wdata;
         end
      end
   end

   if (DEPTH == (1 << BYTE_W)) begin : g_full_map
      assign rdata = cells[raddr[IW-1:0]];
   end else begin : g_part_map
      assign rdata = (int'(raddr) < DEPTH) ? cells[raddr[IW-1:0]] : '0;
   end
endmodule

// File: rtl/sbm_sequencer.sv
module sbm_sequencer
   import sbm_pkg::*;
#(
   parameter int                BYTE_W = 8,
   parameter int                DEPTH  = 255,
   parameter logic [BYTE_W-1:0] WR_OP  = 'hF0,
   parameter logic [BYTE_W-1:0] RD_OP  = 'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_idle,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] byte_val,
   input  logic [BYTE_W-1:0] rd_data,
   input  logic              rx_take,
   input  logic              rx_ovf_clr,
   output logic              mem_we,
   output logic [BYTE_W-1:0] mem_waddr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic [BYTE_W-1:0] mem_raddr,
   output logic              tx_load,
   output logic [BYTE_W-1:0] tx_data,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_ready,
   output logic              rx_ovf
);
   if (WR_OP == RD_OP) begin : g_bad_ops
      $error("sbm_sequencer: read and write opcodes must differ");
   end

   slot_e             slot;
   logic [BYTE_W-1:0] op_q, addr_q;

   assign mem_raddr = byte_val;
   assign tx_data   = rd_data;
   assign tx_load   = byte_done && slot == SLOT_ADDR && op_q == RD_OP;
   assign mem_waddr = addr_q;
   assign mem_wdata = byte_val;
   assign mem_we    = byte_done && slot == SLOT_DATA && op_q == WR_OP
                      && int'(addr_q) < DEPTH;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot   <= SLOT_OP;
         op_q   <= '0;
         addr_q <= '0;
      end else if (cs_idle) begin
         slot <= SLOT_OP;
      end else if (byte_done) begin
         unique case (slot)
            SLOT_OP: begin
               op_q <= byte_val;
               slot <= SLOT_ADDR;
            end
            SLOT_ADDR: begin
               addr_q <= byte_val;
               slot   <= SLOT_DATA;
            end
            default: slot <= SLOT_OP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte  <= '0;
         rx_ready <= 1'b0;
         rx_ovf   <= 1'b0;
      end else if (byte_done) begin
         rx_byte  <= byte_val;
         rx_ready <= 1'b1;
         if (rx_ready && !rx_take) rx_ovf <= 1'b1;
         else if (rx_ovf_clr)      rx_ovf <= 1'b0;
      end else begin
         if (rx_take)    rx_ready <= 1'b0;
         if (rx_ovf_clr) rx_ovf   <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_byte_mem_slave.sv
module spi_byte_mem_slave #(
   parameter int                BYTE_W      = 8,
   parameter int                DEPTH       = 255,
   parameter int                SYNC_STAGES = 2,
   parameter logic [BYTE_W-1:0] WR_OP       = 'hF0,
   parameter logic [BYTE_W-1:0] RD_OP       = 'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              spi_cs_n,
   output logic              spi_miso,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_ready,
   input  logic              rx_take,
   output logic              rx_ovf,
   input  logic              rx_ovf_clr
);
   localparam int NPIN   = 3;
   localparam int CS_IDX = 2;

   logic [NPIN-1:0]   pin_raw, pin_lvl;
   logic              cs_idle;
   logic              byte_done, tx_load, mem_we;
   logic [BYTE_W-1:0] byte_val, tx_data, rd_data;
   logic [BYTE_W-1:0] mem_waddr, mem_wdata, mem_raddr;

   assign pin_raw = {spi_cs_n, spi_mosi, spi_sck};

   for (genvar g = 0; g < NPIN; g++) begin : g_sync
      sbm_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (g == CS_IDX)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_in  (pin_raw[g]),
         .q_out (pin_lvl[g])
      );
   end

   assign cs_idle = pin_lvl[CS_IDX];

   sbm_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_idle   (cs_idle),
      .sck_s     (pin_lvl[0]),
      .mosi_s    (pin_lvl[1]),
      .tx_load   (tx_load),
      .tx_data   (tx_data),
      .miso      (spi_miso),
      .byte_done (byte_done),
      .byte_val  (byte_val)
   );

   sbm_sequencer #(
      .BYTE_W (BYTE_W),
      .DEPTH  (DEPTH),
      .WR_OP  (WR_OP),
      .RD_OP  (RD_OP)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_idle    (cs_idle),
      .byte_done  (byte_done),
      .byte_val   (byte_val),
      .rd_data    (rd_data),
      .rx_take    (rx_take),
      .rx_ovf_clr (rx_ovf_clr),
      .mem_we     (mem_we),
      .mem_waddr  (mem_waddr),
      .mem_wdata  (mem_wdata),
      .mem_raddr  (mem_raddr),
      .tx_load    (tx_load),
      .tx_data    (tx_data),
      .rx_byte    (rx_byte),
      .rx_ready   (rx_ready),
      .rx_ovf     (rx_ovf)
   );

   sbm_store #(
      .BYTE_W (BYTE_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mem_raddr),
      .rdata (rd_data)
   );
endmodule

// File: rtl/spi_byte_mem_slave_chk.sv
module spi_byte_mem_slave_chk #(
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 255
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_idle,
   input logic              byte_done,
   input logic [BYTE_W-1:0] byte_val,
   input logic              mem_we,
   input logic [BYTE_W-1:0] mem_waddr,
   input logic              tx_load,
   input logic              spi_miso,
   input logic [BYTE_W-1:0] rx_byte,
   input logic              rx_ready,
   input logic              rx_take,
   input logic              rx_ovf,
   input logic              rx_ovf_clr
);
   logic [1:0] pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pos <= 2'd0;
      else if (cs_idle)    pos <= 2'd0;
      else if (byte_done)  pos <= (pos == 2'd2) ? 2'd0 : pos + 2'd1;
   end

   // R2 / R6: stores happen only on the third byte of a frame
   assert_write_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (byte_done && pos == 2'd2));

   // R3 / R6: read data is loaded on completion of the address byte
   assert_load_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> (byte_done && pos == 2'd1));

   assert_no_store_oob_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (int'(mem_waddr) < DEPTH));

   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |-> (!byte_done && !mem_we && !tx_load));

   assert_idle_miso_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_idle && $past(cs_idle)) |-> !spi_miso);

   assert_hold_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> (rx_ready && rx_byte == $past(byte_val)));

   assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && rx_ready && !rx_take) |=> rx_ovf);

   assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf_clr && !byte_done) |=> !rx_ovf);
endmodule

bind spi_byte_mem_slave spi_byte_mem_slave_chk #(
   .BYTE_W (BYTE_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_idle    (cs_idle),
   .byte_done  (byte_done),
   .byte_val   (byte_val),
   .mem_we     (mem_we),
   .mem_waddr  (mem_waddr),
   .tx_load    (tx_load),
   .spi_miso   (spi_miso),
   .rx_byte    (rx_byte),
   .rx_ready   (rx_ready),
   .rx_take    (rx_take),
   .rx_ovf     (rx_ovf),
   .rx_ovf_clr (rx_ovf_clr)
);

// File: tb/spi_byte_mem_slave_tb.sv
module spi_byte_mem_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam int DEPTH      = 12;
   localparam logic [7:0] OP_WR = 8'hF0;
   localparam logic [7:0] OP_RD = 8'h0F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
   logic       miso;
   logic [7:0] rx_byte;
   logic       rx_ready, rx_ovf;
   logic       rx_take = 1'b0, rx_ovf_clr = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_byte_mem_slave #(.BYTE_W(8), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
      .spi_miso(miso), .rx_byte(rx_byte), .rx_ready(rx_ready), .rx_take(rx_take),
      .rx_ovf(rx_ovf), .rx_ovf_clr(rx_ovf_clr)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 29 + 8'h3B) ^ (a << 4));
   endfunction

   function automatic logic [7:0] expect_mem(input int a, input logic [7:0] v);
      return (a < DEPTH) ? v : 8'h00;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // clock idle low: master drives on rising, samples on falling (R4)
   task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
      rx = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         sck = 1'b1; mosi = tx[i];
         cyc(HALF);
         rx[i] = miso;
         sck = 1'b0;
         cyc(HALF);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      xfer_bits(tx, 8, rx);
   endtask

   task automatic cs_on();
      cs_n = 1'b0; cyc(HALF);
   endtask

   task automatic cs_off();
      cyc(2); cs_n = 1'b1; cyc(8);
   endtask

   task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2);
      cs_on();
      xfer(b0, r0); xfer(b1, r1); xfer(b2, r2);
      cs_off();
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] r0, r1, r2;
      frame(OP_WR, a, d, r0, r1, r2);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      logic [7:0] r0, r1;
      frame(OP_RD, a, 8'hFF, r0, r1, d);
   endtask

   task automatic pulse_take();
      rx_take = 1'b1; cyc(1); rx_take = 1'b0; cyc(1);
   endtask

   task automatic pulse_clr();
      rx_ovf_clr = 1'b1; cyc(1); rx_ovf_clr = 1'b0; cyc(1);
   endtask

   initial begin
      logic [7:0] r0, r1, r2, d;
      logic [7:0] shadow [16];
      cyc(5);
      rst_n = 1'b1;
      cyc(4);
      check("R11 reset miso", miso, 1'b0);
      check("R9 reset rx_ready", rx_ready, 1'b0);
      check("R10 reset rx_ovf", rx_ovf, 1'b0);

      // R3: bytes 1 and 2 of a read frame carry zero
      frame(OP_RD, 8'h02, 8'hFF, r0, r1, r2);
      check("R3 read byte1 miso", r0, 8'h00);
      check("R3 read byte2 miso", r1, 8'h00);
      check("R7 reset contents addr2", r2, 8'h00);

      // R7/R8: everything reads zero after reset, including holes
      for (int a = 0; a < 16; a++) begin
         rd(8'(a), d);
         check($sformatf("R7 cleared addr %0d", a), d, 8'h00);
         shadow[a] = 8'h00;
      end
      rd(8'hFF, d);
      check("R8 read 0xFF after reset", d, 8'h00);

      // R2/R4/R8: write sweep, then read back with distinct patterns
      for (int a = 0; a < 16; a++) begin
         wr(8'(a), pat(a));
         shadow[a] = expect_mem(a, pat(a));
      end
      wr(8'hFF, 8'hA5);
      for (int a = 0; a < 16; a++) begin
         rd(8'(a), d);
         check($sformatf("R2 R4 R8 readback addr %0d", a), d, shadow[a]);
      end
      rd(8'hFF, d);
      check("R8 write to 0xFF ignored", d, 8'h00);

      // R1: unknown opcodes store nothing and return zeros
      begin
         logic [7:0] bad [5] = '{8'h00, 8'hFF, 8'hF1, 8'h0E, 8'h1F};
         foreach (bad[k]) begin
            frame(bad[k], 8'h03, ~pat(3), r0, r1, r2);
            check("R1 unknown op miso", {r0, r1, r2}, 24'h0);
         end
      end
      rd(8'h03, d);
      check("R1 unknown op left addr3", d, shadow[3]);
      // R1: third byte of a read frame is discarded
      frame(OP_RD, 8'h04, 8'h77, r0, r1, r2);
      check("R1 read frame returns addr4", r2, shadow[4]);
      rd(8'h04, d);
      check("R1 read dummy discarded", d, shadow[4]);

      // R5: short frames leave memory unchanged and realign
      cs_on(); xfer(OP_WR, r0); cs_off();
      cs_on(); xfer(OP_WR, r0); xfer(8'h05, r1); cs_off();
      cs_on(); xfer(OP_WR, r0); xfer(8'h05, r1); xfer_bits(8'h11, 4, r2); cs_off();
      rd(8'h05, d);
      check("R5 partial frames no store", d, shadow[5]);
      cs_on(); xfer(OP_WR, r0); xfer_bits(8'h00, 3, r1); cs_off();
      wr(8'h05, 8'hC3); shadow[5] = 8'hC3;
      rd(8'h05, d);
      check("R5 realigned write", d, 8'hC3);

      // R6: several frames under one chip select
      cs_on();
      xfer(OP_WR, r0); xfer(8'h06, r1); xfer(8'h5A, r2);
      xfer(OP_RD, r0); xfer(8'h06, r1); xfer(8'hFF, r2);
      check("R6 back-to-back read", r2, 8'h5A);
      xfer(OP_WR, r0); xfer(8'h07, r1); xfer(8'h81, r2);
      cs_off();
      shadow[6] = 8'h5A; shadow[7] = 8'h81;
      rd(8'h07, d);
      check("R6 second write in one select", d, 8'h81);

      // R11: SCK toggles while deselected do not shift alignment
      mosi = 1'b1;
      for (int k = 0; k < 3; k++) begin
         sck = 1'b1; cyc(HALF); sck = 1'b0; cyc(HALF);
      end
      check("R11 miso idle under stray clocks", miso, 1'b0);
      wr(8'h08, 8'h96); shadow[8] = 8'h96;
      rd(8'h08, d);
      check("R11 alignment after stray clocks", d, 8'h96);

      // R9/R10: receive holding register and overflow
      pulse_take(); pulse_clr();
      check("R9 take clears ready", rx_ready, 1'b0);
      check("R10 clear drops ovf", rx_ovf, 1'b0);
      cs_on(); xfer(8'h3C, r0); cs_off();
      check("R9 ready after byte", rx_ready, 1'b1);
      check("R9 held byte", rx_byte, 8'h3C);
      check("R10 no ovf on first byte", rx_ovf, 1'b0);
      cs_on(); xfer(8'hA7, r0); cs_off();
      check("R10 ovf on untaken byte", rx_ovf, 1'b1);
      check("R9 newest byte held", rx_byte, 8'hA7);
      pulse_clr();
      check("R10 ovf cleared", rx_ovf, 1'b0);
      check("R9 ready unaffected by clear", rx_ready, 1'b1);
      pulse_take();
      check("R9 ready cleared by take", rx_ready, 1'b0);

      // final sweep: nothing above disturbed stored contents (R5 R1)
      for (int a = 0; a < 16; a++) begin
         rd(8'(a), d);
         check($sformatf("R2 final addr %0d", a), d, shadow[a]);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule